// File: doc/BRIEF.md
# Master Interrupt Routing Controller

This block gathers 32 level-sensitive interrupt sources and forwards them as processor interrupt levels to one selectable CPU out of up to sixteen. Every source bit is captured into a pending register on each clock. A fixed, irregular table maps each source position to a level between 1 and 15. Several sources share one level, and five positions map to no level at all. The levels of all pending sources that are not disabled are ORed into a 16-bit vector. Only the CPU named by the target register receives that vector.

Sources at level 15 are treated separately. While any of them is pending, bit 15 is raised on every CPU's vector, whatever the individual disable bits say. A separate one-bit output also reports such a source as pending. The top bit of the disable register is a global kill switch. While it is set, no level reaches any CPU.

Software reaches the block through a single-cycle port addressed by word index. The port can read the pending and disable registers. It can clear or set disable bits through separate write-one strobes, and it can read and write the target CPU. Internally the write strobe is decoded into one of four access kinds: ACC_NONE, ACC_ENABLE, ACC_DISABLE and ACC_TARGET. Each kind is used for one cycle and then discarded. There is no other state sequencing.

Top module: `intr_master_router`

## Requirements
- R1: After reset the pending register is 0, the target is CPU 0, and the disable register holds 0x0fa2007f. Reading word 1 therefore returns 0, and every CPU vector and the broadcast output are 0.
- R2: Word index 0 reads pending, 1 reads disable, and 4 reads the target. Reads of words 2, 3, 5, 6 and 7 return 0. Writes to words 0, 1, 5, 6 and 7 change nothing.
- R3: A read of word 0 returns the pending bits with bit 31 forced to 0. A read of word 1 returns the disable register ANDed with 0xf05dff80.
- R4: Writing ones to word 2 clears those disable bits, and writing ones to word 3 sets them. Both writes are first ANDed with 0xf05dff80, so disable bits 0–6, 17, 21 and 23–27 keep their reset value of 1 for good.
- R5: A pending bit equals the source input sampled at the previous clock edge. Sources 23, 24, 25, 26 and 31 map to level 0 and never become pending.
- R6: Setting or clearing a disable bit leaves the pending register unchanged.
- R7: Source bits 0..31 map to levels 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0. The target vector sets bit L for each pending, non-disabled source of level L. Bit 0 of a vector is always 0.
- R8: CPUs other than the target receive no levels from the table. Only bit 15 from the broadcast can be set in their vectors.
- R9: A write to word 4 keeps only bits 3:0 of the written data as the target CPU number.
- R10: While any source 27–30 is pending and the master disable is clear, bit 15 is set in every CPU's vector, regardless of the individual disable bits. The broadcast output is 1 whenever any of these sources is pending.
- R11: While disable bit 31 is set, every CPU vector is 0.
- R12: A register write accepted at one clock edge changes the read data and the CPU vectors immediately after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl_i | input | 32 | Level-sensitive source inputs |
| bus_wr_i | input | 1 | Write strobe, one access per cycle |
| bus_idx_i | input | 3 | Word index of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_idx_i (combinational) |
| cpu_lvl_o | output | N_CPU*16 | Level vector per CPU; CPU c uses bits c*16+15 : c*16 |
| l15_bcast_o | output | 1 | A level-15 source is pending |

## Verification
The checker watches properties that hold on every cycle:
- at most one CPU carries table levels;
- the master disable silences all vectors;
- the disable positions that cannot be written never move;
- the target register captures the low nibble of a write;
- word 0 never shows bit 31;
- no vector ever sets bit 0.

Only the bench scenarios can show the rest:
- the level table itself;
- the broadcast that bypasses the individual disable bits;
- disable writes that leave pending untouched;
- the one-edge latency.

The bench's reference model checks all of these on every clock, during both the directed steps and a long randomised run.

// File: rtl/intr_pkg.sv
package intr_pkg;

    localparam int SRC_W = 32;
    localparam int LVL_W = 16;
    localparam int TGT_W = 4;
    localparam int IDX_W = 3;
    localparam int MDIS_BIT = 31;

    // Disable bits that software may alter
    localparam logic [SRC_W-1:0] SRC_VALID = 32'hf05d_ff80;
    // Disable register value after reset
    localparam logic [SRC_W-1:0] DIS_RESET = 32'h0fa2_007f;

    typedef enum logic [IDX_W-1:0] {
        IX_PEND  = 3'd0,
        IX_DIS   = 3'd1,
        IX_EN_W  = 3'd2,
        IX_DIS_W = 3'd3,
        IX_TGT   = 3'd4
    } reg_ix_e;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_ENABLE,
        ACC_DISABLE,
        ACC_TARGET
    } acc_e;

    function automatic logic [3:0] src_level(input int unsigned b);
        logic [3:0] l;
        case (b)
            0, 7:             l = 4'd2;
            1, 8:             l = 4'd3;
            2, 9:             l = 4'd5;
            3, 10:            l = 4'd7;
            4, 11, 21:        l = 4'd9;
            5, 12, 22:        l = 4'd11;
            6, 13, 17:        l = 4'd13;
            14, 15:           l = 4'd12;
            16:               l = 4'd6;
            18:               l = 4'd4;
            19:               l = 4'd10;
            20:               l = 4'd8;
            27, 28, 29, 30:   l = 4'd15;
            default:          l = 4'd0;
        endcase
        return l;
    endfunction

    function automatic logic [SRC_W-1:0] live_mask();
        logic [SRC_W-1:0] m;
        for (int b = 0; b < SRC_W; b++) m[b] = (src_level(b) != 4'd0);
        return m;
    endfunction

    function automatic logic [SRC_W-1:0] top_level_mask();
        logic [SRC_W-1:0] m;
        for (int b = 0; b < SRC_W; b++) m[b] = (src_level(b) == 4'd15);
        return m;
    endfunction

endpackage

// File: rtl/intr_pend.sv
module intr_pend
    import intr_pkg::*;
#(
    parameter int W = SRC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] pend_o
);

    localparam logic [SRC_W-1:0] LIVE = live_mask();

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (LIVE[b]) begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= src_i[b];
            end
            assign pend_o[b] = bit_q;
        end else begin : g_dead
            assign pend_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/intr_regs.sv
module intr_regs
    import intr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [SRC_W-1:0] wdata_i,
    input  logic [SRC_W-1:0] pend_i,
    output logic [SRC_W-1:0] dis_o,
    output logic [TGT_W-1:0] tgt_o,
    output logic [SRC_W-1:0] rdata_o
);

    acc_e             acc;
    logic [SRC_W-1:0] dis_q;
    logic [TGT_W-1:0] tgt_q;
    logic [SRC_W-1:0] wmask;

    assign wmask = wdata_i & SRC_VALID;

    // Decode the access kind for this cycle
    always_comb begin
        acc = ACC_NONE;
        if (wr_i) begin
            case (idx_i)
                IX_EN_W:  acc = ACC_ENABLE;
                IX_DIS_W: acc = ACC_DISABLE;
                IX_TGT:   acc = ACC_TARGET;
                default:  acc = ACC_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= DIS_RESET;
            tgt_q <= '0;
        end else begin
            unique case (acc)
                ACC_ENABLE:  dis_q <= dis_q & ~wmask;
                ACC_DISABLE: dis_q <= dis_q | wmask;
                ACC_TARGET:  tgt_q <= wdata_i[TGT_W-1:0];
                ACC_NONE:    ;
            endcase
        end
    end

    always_comb begin
        case (idx_i)
            IX_PEND: rdata_o = pend_i & ~(SRC_W'(1) << MDIS_BIT);
            IX_DIS:  rdata_o = dis_q & SRC_VALID;
            IX_TGT:  rdata_o = SRC_W'(tgt_q);
            default: rdata_o = '0;
        endcase
    end

    assign dis_o = dis_q;
    assign tgt_o = tgt_q;

endmodule

// File: rtl/intr_route.sv
module intr_route
    import intr_pkg::*;
#(
    parameter int N_CPU = 16
) (
    input  logic [SRC_W-1:0]       pend_i,
    input  logic [SRC_W-1:0]       dis_i,
    input  logic [TGT_W-1:0]       tgt_i,
    output logic [N_CPU*LVL_W-1:0] cpu_lvl_o,
    output logic                   l15_o
);

    localparam logic [SRC_W-1:0] TOP_MASK = top_level_mask();

    logic [SRC_W-1:0] eff;
    logic [LVL_W-1:0] routed;
    logic             mdis;
    logic             bcast;

    assign mdis  = dis_i[MDIS_BIT];
    assign eff   = pend_i & ~dis_i;
    assign l15_o = |(pend_i & TOP_MASK);
    assign bcast = l15_o & ~mdis;

    always_comb begin
        routed = '0;
        for (int b = 0; b < SRC_W; b++) begin
            if (eff[b]) routed[src_level(b)] = 1'b1;
        end
        routed[0] = 1'b0;
    end

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        logic sel;
        assign sel = ~mdis & (tgt_i == TGT_W'(c));
        assign cpu_lvl_o[c*LVL_W +: LVL_W] =
            ({LVL_W{sel}} & routed) | {bcast, {(LVL_W-1){1'b0}}};
    end

endmodule

// File: rtl/intr_master_router.sv
module intr_master_router
    import intr_pkg::*;
#(
    parameter int N_CPU = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [31:0]            src_lvl_i,
    input  logic                   bus_wr_i,
    input  logic [2:0]             bus_idx_i,
    input  logic [31:0]            bus_wdata_i,
    output logic [31:0]            bus_rdata_o,
    output logic [N_CPU*16-1:0]    cpu_lvl_o,
    output logic                   l15_bcast_o
);

    logic [SRC_W-1:0] pend_q;
    logic [SRC_W-1:0] dis_q;
    logic [TGT_W-1:0] tgt_q;

    intr_pend #(.W(SRC_W)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_lvl_i),
        .pend_o (pend_q)
    );

    intr_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i),
        .idx_i   (bus_idx_i),
        .wdata_i (bus_wdata_i),
        .pend_i  (pend_q),
        .dis_o   (dis_q),
        .tgt_o   (tgt_q),
        .rdata_o (bus_rdata_o)
    );

    intr_route #(.N_CPU(N_CPU)) u_route (
        .pend_i    (pend_q),
        .dis_i     (dis_q),
        .tgt_i     (tgt_q),
        .cpu_lvl_o (cpu_lvl_o),
        .l15_o     (l15_bcast_o)
    );

endmodule

// File: rtl/intr_router_chk.sv
module intr_router_chk
    import intr_pkg::*;
#(
    parameter int N_CPU = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr_i,
    input logic [2:0]             bus_idx_i,
    input logic [31:0]            bus_wdata_i,
    input logic [31:0]            bus_rdata_o,
    input logic [N_CPU*16-1:0]    cpu_lvl_o,
    input logic [31:0]            dis_q,
    input logic [3:0]             tgt_q
);

    logic [N_CPU-1:0] busy;
    logic [N_CPU-1:0] zero_bits;

    for (genvar c = 0; c < N_CPU; c++) begin : g_c
        assign busy[c]      = |cpu_lvl_o[c*16 +: 15];
        assign zero_bits[c] = cpu_lvl_o[c*16];
    end

    // R8
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy));

    // R11
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_q[31] |-> (cpu_lvl_o == '0));

    // R4
    fixed_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(dis_q & ~SRC_VALID));

    // R9
    target_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_idx_i == 3'd4) |=> (tgt_q == $past(bus_wdata_i[3:0])));

    // R3
    pend_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idx_i == 3'd0) |-> !bus_rdata_o[31]);

    // R7
    no_level0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_bits == '0);

endmodule

bind intr_master_router intr_router_chk #(.N_CPU(N_CPU)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr_i),
    .bus_idx_i   (bus_idx_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .cpu_lvl_o   (cpu_lvl_o),
    .dis_q       (dis_q),
    .tgt_q       (tgt_q)
);

// File: tb/sim_intr_master_router.sv
`timescale 1ns/1ps
module sim_intr_master_router;

    localparam int NC = 16;
    localparam logic [31:0] VALID = 32'hf05d_ff80;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     src = '0;
    logic            wr = 1'b0;
    logic [2:0]      idx = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NC*16-1:0] lvl;
    logic            l15;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int tab [0:31] = '{2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,
                       6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0};

    logic [31:0] m_pend, m_dis;
    int          m_tgt;

    always #2 clk = ~clk;

    intr_master_router #(.N_CPU(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .src_lvl_i(src), .bus_wr_i(wr),
        .bus_idx_i(idx), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .cpu_lvl_o(lvl), .l15_bcast_o(l15)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_vec(input int c);
        logic [15:0] v = '0;
        if (!m_dis[31]) begin
            if (c == m_tgt)
                for (int b = 0; b < 32; b++)
                    if (m_pend[b] && !m_dis[b] && tab[b] != 0) v[tab[b]] = 1'b1;
            for (int b = 27; b <= 30; b++) if (m_pend[b]) v[15] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [31:0] exp_rd(input int i);
        case (i)
            0: return m_pend & 32'h7fff_ffff;
            1: return m_dis & VALID;
            4: return 32'(m_tgt);
            default: return 32'h0;
        endcase
    endfunction

    // One clock: advance the model at the edge, compare at the falling edge
    task automatic cyc();
        @(posedge clk);
        if (!rst_n) begin
            m_pend = '0; m_dis = 32'h0fa2_007f; m_tgt = 0;
        end else begin
            if (wr) begin
                case (idx)
                    3'd2: m_dis = m_dis & ~(wdata & VALID);
                    3'd3: m_dis = m_dis | (wdata & VALID);
                    3'd4: m_tgt = int'(wdata[3:0]);
                    default: ;
                endcase
            end
            m_pend = '0;
            for (int b = 0; b < 32; b++) if (tab[b] != 0) m_pend[b] = src[b];
        end
        @(negedge clk);
        chk("R2 R3 R12 readback", rdata, exp_rd(int'(idx)));
        for (int c = 0; c < NC; c++)
            chk($sformatf("R8 R12 cpu%0d vector", c), 32'(lvl[c*16 +: 16]), 32'(exp_vec(c)));
        chk("R10 broadcast flag", 32'(l15), 32'(|m_pend[30:27]));
    endtask

    task automatic wreg(input int i, input logic [31:0] d);
        wr = 1'b1; idx = 3'(i); wdata = d;
        cyc();
        wr = 1'b0;
    endtask

    task automatic rd(input int i, output logic [31:0] d);
        idx = 3'(i);
        #1;
        d = rdata;
    endtask

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        m_pend = '0; m_dis = 32'h0fa2_007f; m_tgt = 0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        rd(0, d); chk("R1 pending", d, 32'h0);
        rd(1, d); chk("R1 disable read", d, 32'h0);
        rd(4, d); chk("R1 target", d, 32'h0);
        chk("R1 vectors", 32'(|lvl), 32'h0);

        // R4 enable-all leaves fixed positions disabled
        wreg(2, 32'hffff_ffff);
        rd(1, d); chk("R4 disable after enable-all", d, 32'h0);

        // R7 source 7 -> level 2 on cpu0
        src = 32'h0000_0080; cyc();
        chk("R7 src7 level2", 32'(lvl[15:0]), 32'h0004);
        rd(0, d); chk("R5 pending src7", d, 32'h80);

        // R5 level-0 sources never pend
        src = 32'h8780_0000; cyc();
        rd(0, d); chk("R5 dead sources", d, 32'h0);

        // R4 source 0 pends but stays disabled
        src = 32'h0000_0001; wreg(2, 32'h1);
        rd(0, d); chk("R4 src0 pending", d, 32'h1);
        chk("R4 src0 blocked", 32'(lvl[15:0]), 32'h0);

        // R6 disabling keeps pending
        src = 32'h0000_0100; cyc();
        chk("R7 src8 level3", 32'(lvl[15:0]), 32'h0008);
        wreg(3, 32'h100);
        chk("R6 disabled no level", 32'(lvl[15:0]), 32'h0);
        rd(0, d); chk("R6 pending kept", d, 32'h100);
        wreg(2, 32'h100);
        chk("R6 re-enabled", 32'(lvl[15:0]), 32'h0008);

        // R9 target keeps low nibble
        wreg(4, 32'h25);
        rd(4, d); chk("R9 target", d, 32'h5);
        chk("R8 cpu5 gets level", 32'(lvl[5*16 +: 16]), 32'h0008);
        chk("R8 cpu0 empty", 32'(lvl[15:0]), 32'h0);

        // R10 broadcast, even for permanently disabled source 27
        src = 32'h0800_0000; cyc();
        chk("R10 cpu0 bit15", 32'(lvl[15:0]), 32'h8000);
        chk("R10 cpu15 bit15", 32'(lvl[15*16 +: 16]), 32'h8000);
        chk("R10 flag", 32'(l15), 32'h1);

        // R11 master disable
        src = 32'h1000_0100; wreg(3, 32'h8000_0000);
        chk("R11 all silent", 32'(|lvl), 32'h0);
        rd(1, d); chk("R11 master bit readback", d, 32'h8000_0000);

        // R2 writes to read-only / undefined words ignored
        wreg(1, 32'h0); wreg(0, 32'hffff_ffff); wreg(6, 32'hffff_ffff);
        rd(1, d); chk("R2 disable untouched", d, 32'h8000_0000);
        rd(6, d); chk("R2 undefined reads zero", d, 32'h0);
        rd(3, d); chk("R2 write-only reads zero", d, 32'h0);
        wreg(2, 32'h8000_0000);

        // Randomised run against the model
        for (int n = 0; n < 3000; n++) begin
            src = $urandom;
            wr  = ($urandom % 3) == 0;
            idx = 3'($urandom % 8);
            wdata = $urandom;
            if (idx == 3'd3 && ($urandom % 4) != 0) wdata[31] = 1'b0;
            cyc();
        end
        wr = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule